// File: doc/BRIEF.md
# Two-Slot PCM Serial Transceiver

This block moves audio samples between a parallel register side and a serial codec bus in PCM or I2S style. The bus is driven by an external bit clock and a frame-sync strobe. Each frame has two time slots: slot 0 carries the left channel and slot 1 the right. For every channel and for each direction, the block takes its own start offset, counted in bit clocks from the frame-sync edge, its own word length and its own bit order. Receive and transmit words may therefore differ in length and position.

All logic runs on one system clock. The bit clock, frame sync and serial input are registered, and their edges are detected in the system clock domain. A bit counter restarts on each new frame-sync assertion. Output bits are launched on bit-clock rising edges and input bits are captured on falling edges. Each channel has a one-word holding register with a valid/ready handshake in each direction. The serial output has a separate enable for an external tri-state pad. The enable is low between words and can be forced low permanently.

Top module: `pcm_slot_xcvr`

## Requirements
- R1: After reset, `sdout_oe` and `sdout` are 0, `tx_ready` is all ones, `rx_valid`, `underrun`, `overrun` and `cfg_err` are all zero, and no output window is active until the first frame sync.
- R2: On a detected bit-clock rising edge, if `fsync` is high and was low at the previous rising edge, that edge is bit position 0. Each later rising edge advances the position by one, saturating at 255.
- R3: Transmit channel c drives positions `tx_off[c]` through `tx_off[c]+L-1`, where L is the effective length. `sdout_oe` is high only in those positions, and `sdout` is 0 whenever `sdout_oe` is low. If the two windows overlap, channel 0 wins.
- R4: With the order bit at 0 (MSB first), bit L-1 of the word goes out or is captured first. With it at 1 (LSB first), bit 0 comes first. The order is chosen separately per channel and per direction.
- R5: The effective length is the 6-bit length field clamped to the range 8 to 32.
- R6: A request for LSB-first with an effective length above 24 is carried out MSB-first. While any such request is applied, `cfg_err` is high, one system clock later.
- R7: While `force_hiz` is high, `sdout_oe` and `sdout` are 0 in the same cycle.
- R8: `tx_ready[c]` is high while channel c's holding register is empty. A word is accepted when `tx_valid` and `tx_ready` are both high. The word is consumed on the rising edge that launches the first bit of the channel's slot, after which `tx_ready` returns high.
- R9: If channel c's holding register is empty when its slot starts, zeros are sent with the enable high, and `underrun[c]` sets and stays set until reset.
- R10: `sdin` is sampled on bit-clock falling edges at positions `rx_off[c]` through `rx_off[c]+L-1`. The word lands right-aligned in `rx_data[c]`, with the bits above L zero. `rx_valid[c]` rises two system clocks after the last falling edge and holds until the word is read with `rx_ready[c]`.
- R11: If a receive word completes while `rx_valid[c]` is high and not being read, `overrun[c]` sets and stays set until reset, and the new word replaces the old one.
- R12: `sdout` and `sdout_oe` change only on the system clock that follows a detected bit-clock rising edge, or when `force_hiz` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame-sync strobe |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out (0 when not enabled) |
| sdout_oe | output | 1 | Output enable for the tri-state pad |
| force_hiz | input | 1 | Keep the output disabled |
| tx_off | input | 2x7 | Transmit start offset per channel |
| tx_len | input | 2x6 | Transmit length field per channel |
| tx_lsb | input | 2 | Transmit LSB-first request per channel |
| rx_off | input | 2x7 | Receive start offset per channel |
| rx_len | input | 2x6 | Receive length field per channel |
| rx_lsb | input | 2 | Receive LSB-first request per channel |
| tx_data | input | 2x32 | Transmit word per channel |
| tx_valid | input | 2 | Transmit word offered |
| tx_ready | output | 2 | Transmit holding register empty |
| rx_data | output | 2x32 | Received word per channel |
| rx_valid | output | 2 | Received word available |
| rx_ready | input | 2 | Received word taken |
| underrun | output | 2 | Sticky transmit underrun per channel |
| overrun | output | 2 | Sticky receive overrun per channel |
| cfg_err | output | 1 | Illegal LSB-first request present |

## Verification
An output bit launched at a bit-clock rising edge appears two system clocks after the bench moves `bclk` high. The bench therefore compares `sdout` and `sdout_oe` three clocks after each rise. It compares them again just before the next rise, to confirm they held. A received word becomes visible two clocks after the last falling edge, so receive words and the sticky flags are checked only after a three-clock idle at the end of the frame. `cfg_err` is checked two clocks after a new configuration is applied. `tx_ready` is checked one clock after each accepted write.

// File: rtl/pcm_xcvr_pkg.sv
package pcm_xcvr_pkg;

    localparam int NCH       = 2;
    localparam int MAX_W     = 32;
    localparam int MIN_W     = 8;
    localparam int LSB_LIMIT = 24;
    localparam int OFF_W     = 7;
    localparam int LEN_W     = 6;
    localparam int CNT_W     = OFF_W + 1;
    localparam int IDX_W     = $clog2(MAX_W);
    localparam logic [CNT_W-1:0] CNT_PARK = '1;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [LEN_W-1:0] len;
        logic             lsb_first;
    } lane_cfg_t;

    typedef struct packed {
        logic             active;
        logic             first;
        logic             last;
        logic [IDX_W-1:0] idx;
    } slot_pos_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(MIN_W)) return LEN_W'(MIN_W);
        if (raw > LEN_W'(MAX_W)) return LEN_W'(MAX_W);
        return raw;
    endfunction

    function automatic logic order_clash(input lane_cfg_t c);
        return c.lsb_first && (clamp_len(c.len) > LEN_W'(LSB_LIMIT));
    endfunction

    function automatic lane_cfg_t resolve(input lane_cfg_t c);
        lane_cfg_t r;
        r.off       = c.off;
        r.len       = clamp_len(c.len);
        r.lsb_first = c.lsb_first && !order_clash(c);
        return r;
    endfunction

    function automatic slot_pos_t locate(input logic [CNT_W-1:0] cnt, input lane_cfg_t c);
        slot_pos_t        p;
        logic [CNT_W-1:0] k;
        logic [CNT_W-1:0] l;
        k        = cnt - CNT_W'(c.off);
        l        = CNT_W'(c.len);
        p.active = (cnt >= CNT_W'(c.off)) && (k < l);
        p.first  = p.active && (k == '0);
        p.last   = p.active && (k == l - 1'b1);
        p.idx    = c.lsb_first ? IDX_W'(k) : IDX_W'(l - 1'b1 - k);
        return p;
    endfunction

endpackage

// File: rtl/pcm_bus_sampler.sv
module pcm_bus_sampler (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fsync,
    input  logic sdin,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fs_lvl,
    output logic din_lvl
);
    logic bclk_q, bclk_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            bclk_qq <= 1'b0;
            fs_lvl  <= 1'b0;
            din_lvl <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            bclk_qq <= bclk_q;
            fs_lvl  <= fsync;
            din_lvl <= sdin;
        end
    end

    assign bclk_rise = bclk_q & ~bclk_qq;
    assign bclk_fall = ~bclk_q & bclk_qq;
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_xcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lane_cfg_t        cfg,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             step,
    input  logic [MAX_W-1:0] wdata,
    input  logic             wvalid,
    output logic             wready,
    output logic             bit_o,
    output logic             act_o,
    output logic             underrun_o
);
    logic             full;
    logic [MAX_W-1:0] hold;
    logic [MAX_W-1:0] word;
    logic [MAX_W-1:0] src;
    slot_pos_t        pos;
    logic             load;

    assign pos    = locate(cnt_nxt, cfg);
    assign load   = step && pos.first;
    assign src    = pos.first ? (full ? hold : '0) : word;
    assign bit_o  = src[pos.idx];
    assign act_o  = pos.active;
    assign wready = ~full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full       <= 1'b0;
            hold       <= '0;
            word       <= '0;
            underrun_o <= 1'b0;
        end else begin
            if (load) begin
                word <= full ? hold : '0;
                if (!full) underrun_o <= 1'b1;
            end
            if (load && full) begin
                full <= 1'b0;
            end else if (wvalid && !full) begin
                full <= 1'b1;
                hold <= wdata;
            end
        end
    end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_xcvr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lane_cfg_t        cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic             step,
    input  logic             din,
    input  logic             rready,
    output logic [MAX_W-1:0] rdata,
    output logic             rvalid,
    output logic             overrun_o
);
    logic [MAX_W-1:0] acc;
    logic [MAX_W-1:0] nxt;
    slot_pos_t        pos;
    logic             done;

    assign pos  = locate(cnt, cfg);
    assign done = step && pos.last;

    always_comb begin
        nxt          = pos.first ? '0 : acc;
        nxt[pos.idx] = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            rdata     <= '0;
            rvalid    <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            if (step && pos.active) acc <= nxt;
            if (done) begin
                rdata  <= nxt;
                rvalid <= 1'b1;
                if (rvalid && !rready) overrun_o <= 1'b1;
            end else if (rvalid && rready) begin
                rvalid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcm_slot_xcvr.sv
module pcm_slot_xcvr
    import pcm_xcvr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bclk,
    input  logic                       fsync,
    input  logic                       sdin,
    output logic                       sdout,
    output logic                       sdout_oe,
    input  logic                       force_hiz,
    input  logic [NCH-1:0][OFF_W-1:0]  tx_off,
    input  logic [NCH-1:0][LEN_W-1:0]  tx_len,
    input  logic [NCH-1:0]             tx_lsb,
    input  logic [NCH-1:0][OFF_W-1:0]  rx_off,
    input  logic [NCH-1:0][LEN_W-1:0]  rx_len,
    input  logic [NCH-1:0]             rx_lsb,
    input  logic [NCH-1:0][MAX_W-1:0]  tx_data,
    input  logic [NCH-1:0]             tx_valid,
    output logic [NCH-1:0]             tx_ready,
    output logic [NCH-1:0][MAX_W-1:0]  rx_data,
    output logic [NCH-1:0]             rx_valid,
    input  logic [NCH-1:0]             rx_ready,
    output logic [NCH-1:0]             underrun,
    output logic [NCH-1:0]             overrun,
    output logic                       cfg_err
);
    logic             bclk_rise, bclk_fall, fs_lvl, din_lvl;
    logic             fs_prev;
    logic             frame_start;
    logic [CNT_W-1:0] bit_cnt, cnt_nxt;
    logic [NCH-1:0]   tx_bit, tx_act, clash;
    logic             nb, na;
    logic             dout_r, oe_r;

    pcm_bus_sampler u_smp (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .sdin(sdin),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .fs_lvl(fs_lvl), .din_lvl(din_lvl)
    );

    assign frame_start = fs_lvl && !fs_prev;
    assign cnt_nxt     = frame_start ? '0 :
                         (bit_cnt == CNT_PARK) ? bit_cnt : bit_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= CNT_PARK;
            fs_prev <= 1'b0;
        end else if (bclk_rise) begin
            bit_cnt <= cnt_nxt;
            fs_prev <= fs_lvl;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        lane_cfg_t tx_raw, rx_raw, tx_eff, rx_eff;
        assign tx_raw   = '{off: tx_off[g], len: tx_len[g], lsb_first: tx_lsb[g]};
        assign rx_raw   = '{off: rx_off[g], len: rx_len[g], lsb_first: rx_lsb[g]};
        assign tx_eff   = resolve(tx_raw);
        assign rx_eff   = resolve(rx_raw);
        assign clash[g] = order_clash(tx_raw) | order_clash(rx_raw);

        pcm_tx_lane u_tx (
            .clk(clk), .rst(rst), .cfg(tx_eff), .cnt_nxt(cnt_nxt), .step(bclk_rise),
            .wdata(tx_data[g]), .wvalid(tx_valid[g]), .wready(tx_ready[g]),
            .bit_o(tx_bit[g]), .act_o(tx_act[g]), .underrun_o(underrun[g])
        );

        pcm_rx_lane u_rx (
            .clk(clk), .rst(rst), .cfg(rx_eff), .cnt(bit_cnt), .step(bclk_fall),
            .din(din_lvl), .rready(rx_ready[g]), .rdata(rx_data[g]),
            .rvalid(rx_valid[g]), .overrun_o(overrun[g])
        );
    end

    always_comb begin
        na = 1'b0;
        nb = 1'b0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (tx_act[c]) begin
                na = 1'b1;
                nb = tx_bit[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_r  <= 1'b0;
            oe_r    <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= |clash;
            if (bclk_rise) begin
                oe_r   <= na;
                dout_r <= na & nb;
            end
        end
    end

    assign sdout_oe = oe_r & ~force_hiz;
    assign sdout    = dout_r & sdout_oe;
endmodule

// File: rtl/pcm_slot_xcvr_chk.sv
module pcm_slot_xcvr_chk
    import pcm_xcvr_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           bclk_rise,
    input logic           force_hiz,
    input logic           sdout,
    input logic           sdout_oe,
    input logic [NCH-1:0] tx_valid,
    input logic [NCH-1:0] tx_ready,
    input logic [NCH-1:0] rx_valid,
    input logic [NCH-1:0] rx_ready,
    input logic [NCH-1:0] underrun,
    input logic [NCH-1:0] overrun
);
    AST_RESET_HIZ: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sdout_oe);  // R1

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(bclk_rise) && $stable(force_hiz)) |-> ($stable(sdout) && $stable(sdout_oe)));  // R12

    AST_TX_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (|(tx_valid & tx_ready)) |=> (($past(tx_valid & tx_ready) & tx_ready) == '0));  // R8

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        (|(rx_valid & ~rx_ready)) |=> (($past(rx_valid & ~rx_ready) & ~rx_valid) == '0));  // R10

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|underrun) |=> ((underrun & $past(underrun)) == $past(underrun)));  // R9

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|overrun) |=> ((overrun & $past(overrun)) == $past(overrun)));  // R11
endmodule

bind pcm_slot_xcvr pcm_slot_xcvr_chk u_chk (
    .clk(clk), .rst(rst), .bclk_rise(bclk_rise), .force_hiz(force_hiz),
    .sdout(sdout), .sdout_oe(sdout_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .underrun(underrun), .overrun(overrun)
);

// File: tb/tb_pcm_slot_xcvr.sv
module tb_pcm_slot_xcvr;
    import pcm_xcvr_pkg::*;

    localparam int HALF = 4;
    localparam int FB   = 96;
    localparam int NFR  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk = 1'b0, fsync = 1'b0, sdin = 1'b0, force_hiz = 1'b0;
    logic sdout, sdout_oe, cfg_err;
    logic [NCH-1:0][OFF_W-1:0] tx_off = '0, rx_off = '0;
    logic [NCH-1:0][LEN_W-1:0] tx_len = '0, rx_len = '0;
    logic [NCH-1:0]            tx_lsb = '0, rx_lsb = '0;
    logic [NCH-1:0][MAX_W-1:0] tx_data = '0, rx_data;
    logic [NCH-1:0]            tx_valid = '0, tx_ready, rx_valid, rx_ready = '0;
    logic [NCH-1:0]            underrun, overrun;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int to[2], tl[2], tb[2], ro[2], rl[2], rb[2];
    logic [31:0] tw[2], rw[2];
    logic [1:0] exp_und = 2'b00, exp_ovr = 2'b00;
    bit pend0 = 0;

    always #10 clk = ~clk;

    pcm_slot_xcvr dut (.*);

    function automatic int eff_len(int raw);
        if (raw < 8) return 8;
        if (raw > 32) return 32;
        return raw;
    endfunction

    function automatic bit eff_lsb(int lsb, int raw);
        return (lsb != 0) && (eff_len(raw) <= 24);
    endfunction

    function automatic logic bit_at(logic [31:0] w, int len, bit lsb, int k);
        return lsb ? w[k] : w[len-1-k];
    endfunction

    function automatic logic [31:0] mask_of(int len);
        logic [63:0] m;
        m = (64'd1 << len) - 64'd1;
        return m[31:0];
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic set_cfg(input int i);
        to[0] = (i * 7) % 20;
        tl[0] = (i * 11 + 3) % 40;
        tb[0] = i & 1;
        to[1] = to[0] + eff_len(tl[0]) + (i % 4);
        tl[1] = (i * 13 + 20) % 45;
        tb[1] = (i >> 1) & 1;
        ro[0] = (i * 5) % 17;
        rl[0] = (i * 17 + 9) % 42;
        rb[0] = ((i >> 2) ^ i) & 1;
        ro[1] = ro[0] + eff_len(rl[0]) + (i % 3);
        rl[1] = (i * 7 + 30) % 40;
        rb[1] = (i & 1) ^ 1;
        for (int c = 0; c < 2; c++) begin
            tw[c] = 32'(i) * 32'h9E3779B1 + 32'(c) * 32'h7F4A7C15 + 32'h1234;
            rw[c] = 32'(i) * 32'h85EBCA6B + 32'(c) * 32'h2545F491 + 32'h55AA;
        end
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            tx_off[c] = 7'(to[c]); tx_len[c] = 6'(tl[c]); tx_lsb[c] = tb[c][0];
            rx_off[c] = 7'(ro[c]); rx_len[c] = 6'(rl[c]); rx_lsb[c] = rb[c][0];
        end
        repeat (2) @(negedge clk);
        // R6: flag follows an LSB-first request above 24 bits
        chk("R6 cfg_err", 64'(cfg_err),
            64'((tb[0] != 0 && eff_len(tl[0]) > 24) || (tb[1] != 0 && eff_len(tl[1]) > 24) ||
                (rb[0] != 0 && eff_len(rl[0]) > 24) || (rb[1] != 0 && eff_len(rl[1]) > 24)));
    endtask

    task automatic run_frame(input bit skip_wr1, input bit skip_rd0, input bit hiz);
        logic eb, eo;
        for (int c = 0; c < 2; c++) begin
            if (!(skip_wr1 && c == 1)) begin
                chk("R8 tx_ready empty", 64'(tx_ready[c]), 64'd1);
                @(negedge clk);
                tx_data[c] = tw[c];
                tx_valid[c] = 1'b1;
                @(negedge clk);
                tx_valid[c] = 1'b0;
                chk("R8 tx_ready full", 64'(tx_ready[c]), 64'd0);
            end
        end
        force_hiz = hiz;
        for (int p = 0; p < FB; p++) begin
            @(negedge clk);
            bclk = 1'b1;
            fsync = (p == 0);
            sdin = 1'b1;
            for (int c = 1; c >= 0; c--)
                if (p >= ro[c] && p < ro[c] + eff_len(rl[c]))
                    sdin = bit_at(rw[c], eff_len(rl[c]), eff_lsb(rb[c], rl[c]), p - ro[c]);
            eo = 1'b0;
            eb = 1'b0;
            for (int c = 1; c >= 0; c--)
                if (p >= to[c] && p < to[c] + eff_len(tl[c])) begin
                    eo = 1'b1;
                    eb = (skip_wr1 && c == 1) ? 1'b0 :
                         bit_at(tw[c], eff_len(tl[c]), eff_lsb(tb[c], tl[c]), p - to[c]);
                end
            if (hiz) begin eo = 1'b0; eb = 1'b0; end
            repeat (HALF - 1) @(negedge clk);
            chk(hiz ? "R7 sdout_oe" : "R2/R3 sdout_oe", 64'(sdout_oe), 64'(eo));
            chk(hiz ? "R7 sdout" : (skip_wr1 ? "R9 sdout" : "R4/R5 sdout"), 64'(sdout), 64'(eb));
            @(negedge clk);
            bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            chk("R12 held sdout", 64'({sdout_oe, sdout}), 64'({eo, eb}));
        end
        repeat (3) @(negedge clk);
        force_hiz = 1'b0;
        if (skip_wr1) exp_und[1] = 1'b1;
        if (pend0) exp_ovr[0] = 1'b1;
        for (int c = 0; c < 2; c++) begin
            chk("R10 rx_valid", 64'(rx_valid[c]), 64'd1);
            chk(pend0 && c == 0 ? "R11 rx_data replaced" : "R10/R4 rx_data",
                64'(rx_data[c]), 64'(rw[c] & mask_of(eff_len(rl[c]))));
            chk("R8 tx_ready consumed", 64'(tx_ready[c]), 64'd1);
            if (!(skip_rd0 && c == 0)) begin
                @(negedge clk);
                rx_ready[c] = 1'b1;
                @(negedge clk);
                rx_ready[c] = 1'b0;
                chk("R10 rx_valid cleared", 64'(rx_valid[c]), 64'd0);
            end
        end
        pend0 = skip_rd0;
        chk("R9 underrun", 64'(underrun), 64'(exp_und));
        chk("R11 overrun", 64'(overrun), 64'(exp_ovr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sdout_oe", 64'(sdout_oe), 64'd0);
        chk("R1 sdout", 64'(sdout), 64'd0);
        chk("R1 tx_ready", 64'(tx_ready), 64'd3);
        chk("R1 rx_valid", 64'(rx_valid), 64'd0);
        chk("R1 flags", 64'({underrun, overrun, cfg_err}), 64'd0);
        repeat (2 * HALF) begin
            @(negedge clk);
            bclk = ~bclk;
        end
        chk("R1 idle before frame", 64'(sdout_oe), 64'd0);
        for (int i = 0; i < NFR; i++) begin
            set_cfg(i);
            run_frame(i == 5, i == 8, i == 12);
        end
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule